// File: doc/BRIEF.md
# Programming Supply and Reset Sequencer

This controller sits on the programmer side of a one-time-programmable target. It moves the target into and out of programming mode by switching four things in a fixed order. The first is the core-supply enable. The second is the enable for the high-voltage switch on the external-access pin. The third is the enable for the programming-voltage switch. The last is the active-low target reset, together with a 4-bit programming-mode select. The block does not regulate any voltage and does not run the programming algorithm. It guarantees only the order of these outputs and the minimum time between them.

Power-up runs through fixed steps, all with the target held in reset. The core supply comes on first, then the external-access high voltage, then the programming voltage. The mode select is then driven, and only after that is reset released. Shutdown is the mirror image. Reset is asserted at once and stays low. The programming voltage is removed first, then the external-access high voltage, and the core supply last, followed by a decay wait. Each wait is a cycle count taken from its own configuration input. Commands are single-cycle pulses: `start` begins power-up, `done` ends a programming session, and `abort` cuts a power-up short. The `ready` output marks the running state and `idle` marks the fully-off state. The nominal levels, 5 V core and 12.5 V programming, come from the target's own voltage bytes (volts = 20 × byte / 256). The programmer sets these levels elsewhere.

Top module: `prog_seq`

## Requirements
- R1: After reset: `idle`=1; `vcc_en`, `ea_hv_en`, `vpp_en` and `ready` are 0; `tgt_rst_n`=0; `mode_sel`=0.
- R2: A `start` pulse while idle raises `vcc_en` in the next cycle, with `tgt_rst_n`=0 and both high-voltage enables at 0. This state holds for `wait_vcc_up` cycles.
- R3: `ea_hv_en` rises only after the core-supply wait has elapsed, with `vpp_en` still 0. It holds alone for `wait_ea_up` cycles.
- R4: `vpp_en` rises only after the external-access wait has elapsed and only while `ea_hv_en`=1. The next step begins after `wait_vpp_up` cycles.
- R5: At the end of the programming-voltage wait, `mode_sel` takes the value of `cfg_mode`, with reset still low. Reset stays low for a further `wait_mode_setup` cycles.
- R6: `tgt_rst_n`=1 and `ready`=1 only in the running state, which follows the mode setup wait.
- R7: While `tgt_rst_n`=1, `mode_sel` does not change, and changes on `cfg_mode` are ignored.
- R8: `done` in the running state drives `tgt_rst_n` to 0 and `vpp_en` to 0 in the same cycle. `tgt_rst_n` stays 0 through the whole shutdown.
- R9: Shutdown holds the programming voltage off for `wait_hv_down` cycles. It then removes `ea_hv_en` and holds for `wait_hv_down` cycles. It then removes `vcc_en` and holds for `wait_vcc_down` cycles. After that, `idle`=1 and `mode_sel` returns to 0.
- R10: A wait value of 0 behaves as a wait of 1 cycle.
- R11: `abort` during power-up enters shutdown at the first step that applies to the enables that are on. During the core-supply wait it goes straight to the supply-off step. During the external-access wait it goes to the high-voltage removal step. From the programming-voltage wait, the mode setup wait or the running state it goes to the programming-voltage removal step.
- R12: `start` outside idle and `done` outside the running state have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin power-up (pulse) |
| done | input | 1 | End the programming session (pulse) |
| abort | input | 1 | Cut power-up short (pulse) |
| cfg_mode | input | MW | Requested programming-mode select |
| wait_vcc_up | input | CW | Core supply settle cycles |
| wait_ea_up | input | CW | External-access high-voltage settle cycles |
| wait_vpp_up | input | CW | Programming-voltage settle cycles |
| wait_mode_setup | input | CW | Mode select setup before reset release |
| wait_hv_down | input | CW | Cycles after each high-voltage removal |
| wait_vcc_down | input | CW | Core supply decay cycles |
| vcc_en | output | 1 | Core supply enable |
| ea_hv_en | output | 1 | External-access high-voltage enable |
| vpp_en | output | 1 | Programming-voltage enable |
| tgt_rst_n | output | 1 | Target reset, active low |
| mode_sel | output | MW | Programming-mode select to the target |
| ready | output | 1 | Target running in programming mode |
| idle | output | 1 | All supplies off and decayed |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge. They make no assumption about the command pulses, since the block must tolerate any command in any state. The stimulus drives commands as one-cycle pulses on the falling edge, and it changes the wait inputs only while the block is idle. This matters because a wait value is read when its step is entered. The stimulus also changes `cfg_mode` while the target is running, to show that the captured mode stays as it was.

// File: rtl/prog_seq.sv
module prog_seq #(
  parameter int MW = 4,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          done,
  input  logic          abort,
  input  logic [MW-1:0] cfg_mode,
  input  logic [CW-1:0] wait_vcc_up,
  input  logic [CW-1:0] wait_ea_up,
  input  logic [CW-1:0] wait_vpp_up,
  input  logic [CW-1:0] wait_mode_setup,
  input  logic [CW-1:0] wait_hv_down,
  input  logic [CW-1:0] wait_vcc_down,
  output logic          vcc_en,
  output logic          ea_hv_en,
  output logic          vpp_en,
  output logic          tgt_rst_n,
  output logic [MW-1:0] mode_sel,
  output logic          ready,
  output logic          idle
);

  typedef enum logic [3:0] {
    S_OFF, S_VCC_UP, S_EA_UP, S_VPP_UP, S_SETUP, S_RUN, S_VPP_DN, S_EA_DN, S_VCC_DN
  } state_t;

  state_t        st, nxt;
  logic [CW-1:0] cnt, ld;
  logic [MW-1:0] mode_q;
  logic          expired;

  assign expired = (cnt == '0);

  function automatic logic [CW-1:0] to_cnt(input logic [CW-1:0] w);
    return (w == '0) ? '0 : w - CW'(1);
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:    if (start) nxt = S_VCC_UP;
      S_VCC_UP: if (abort) nxt = S_VCC_DN; else if (expired) nxt = S_EA_UP;
      S_EA_UP:  if (abort) nxt = S_EA_DN;  else if (expired) nxt = S_VPP_UP;
      S_VPP_UP: if (abort) nxt = S_VPP_DN; else if (expired) nxt = S_SETUP;
      S_SETUP:  if (abort) nxt = S_VPP_DN; else if (expired) nxt = S_RUN;
      S_RUN:    if (abort || done) nxt = S_VPP_DN;
      S_VPP_DN: if (expired) nxt = S_EA_DN;
      S_EA_DN:  if (expired) nxt = S_VCC_DN;
      S_VCC_DN: if (expired) nxt = S_OFF;
      default:  nxt = S_OFF;
    endcase
  end

  always_comb begin
    case (nxt)
      S_VCC_UP: ld = to_cnt(wait_vcc_up);
      S_EA_UP:  ld = to_cnt(wait_ea_up);
      S_VPP_UP: ld = to_cnt(wait_vpp_up);
      S_SETUP:  ld = to_cnt(wait_mode_setup);
      S_VPP_DN: ld = to_cnt(wait_hv_down);
      S_EA_DN:  ld = to_cnt(wait_hv_down);
      S_VCC_DN: ld = to_cnt(wait_vcc_down);
      default:  ld = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      mode_q <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) cnt <= ld;
      else if (!expired) cnt <= cnt - CW'(1);
      if (nxt == S_SETUP && st != S_SETUP) mode_q <= cfg_mode;
      else if (nxt == S_OFF && st != S_OFF) mode_q <= '0;
    end
  end

  assign vcc_en    = st inside {S_VCC_UP, S_EA_UP, S_VPP_UP, S_SETUP, S_RUN, S_VPP_DN, S_EA_DN};
  assign ea_hv_en  = st inside {S_EA_UP, S_VPP_UP, S_SETUP, S_RUN, S_VPP_DN};
  assign vpp_en    = st inside {S_VPP_UP, S_SETUP, S_RUN};
  assign tgt_rst_n = (st == S_RUN);
  assign ready     = (st == S_RUN);
  assign idle      = (st == S_OFF);
  assign mode_sel  = mode_q;

endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vcc_en,
  input logic          ea_hv_en,
  input logic          vpp_en,
  input logic          tgt_rst_n,
  input logic [MW-1:0] mode_sel,
  input logic          ready,
  input logic          idle
);

  assert_ea_needs_vcc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ea_hv_en |-> vcc_en);

  assert_ea_rise_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ea_hv_en) |-> ($past(vcc_en) && !vpp_en && !tgt_rst_n));

  assert_vpp_needs_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> ea_hv_en);

  assert_vpp_rise_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> ($past(ea_hv_en) && !tgt_rst_n));

  assert_release_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_rst_n) |-> ($past(vpp_en) && $stable(mode_sel)));

  assert_ready_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (tgt_rst_n && vpp_en && !idle));

  assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_n |-> $stable(mode_sel));

  assert_reset_with_vpp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst_n |-> vpp_en);

  assert_vcc_fall_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> (!ea_hv_en && !vpp_en && !tgt_rst_n));

  assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!vcc_en && !tgt_rst_n && !ready));

endmodule

bind prog_seq prog_seq_chk #(.MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_en(vcc_en), .ea_hv_en(ea_hv_en),
  .vpp_en(vpp_en), .tgt_rst_n(tgt_rst_n), .mode_sel(mode_sel),
  .ready(ready), .idle(idle)
);

// File: tb/sim_prog_seq.sv
`timescale 1ns/1ps
module sim_prog_seq;
  localparam int MW = 4;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, start = 0, done = 0, abort = 0;
  logic [MW-1:0] cfg_mode = '0;
  logic [CW-1:0] w_vu = 1, w_eu = 1, w_pu = 1, w_ms = 1, w_hd = 1, w_vd = 1;
  logic vcc_en, ea_hv_en, vpp_en, tgt_rst_n, ready, idle;
  logic [MW-1:0] mode_sel;

  int tests = 0, fails = 0, rst_bad = 0;
  bit watch = 0, finished = 0;

  always #4 clk = ~clk;

  prog_seq #(.MW(MW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .abort(abort),
    .cfg_mode(cfg_mode), .wait_vcc_up(w_vu), .wait_ea_up(w_eu),
    .wait_vpp_up(w_pu), .wait_mode_setup(w_ms), .wait_hv_down(w_hd),
    .wait_vcc_down(w_vd), .vcc_en(vcc_en), .ea_hv_en(ea_hv_en),
    .vpp_en(vpp_en), .tgt_rst_n(tgt_rst_n), .mode_sel(mode_sel),
    .ready(ready), .idle(idle)
  );

  always @(negedge clk) if (watch && tgt_rst_n) rst_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [CW-1:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  function automatic bit obs(input int sel);
    case (sel)
      0: return vcc_en;
      1: return ea_hv_en;
      2: return vpp_en;
      3: return tgt_rst_n;
      default: return idle;
    endcase
  endfunction

  task automatic span(input int sel, input bit lvl, output int n);
    n = 0;
    while (obs(sel) == lvl && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic set_waits(input int a, b, c, d, e, f);
    w_vu = CW'(a); w_eu = CW'(b); w_pu = CW'(c); w_ms = CW'(d); w_hd = CW'(e); w_vd = CW'(f);
  endtask

  task automatic power_up(input logic [MW-1:0] m);
    int n;
    cfg_mode = m;
    pulse(start);
    chk(vcc_en && !ea_hv_en && !vpp_en && !tgt_rst_n && !idle, "R2 supply step", vcc_en, 1);
    span(1, 0, n);
    chk(n == eff(w_vu), "R2/R10 core wait", n, eff(w_vu));
    chk(ea_hv_en && !vpp_en && vcc_en && !tgt_rst_n, "R3 ea step", vpp_en, 0);
    span(2, 0, n);
    chk(n == eff(w_eu), "R3/R10 ea wait", n, eff(w_eu));
    chk(vpp_en && ea_hv_en && !tgt_rst_n, "R4 vpp step", tgt_rst_n, 0);
    repeat (eff(w_pu) - 1) @(negedge clk);
    chk(mode_sel == 0 && !tgt_rst_n, "R4 mode not yet driven", mode_sel, 0);
    @(negedge clk);
    chk(mode_sel == m && !tgt_rst_n, "R5 mode driven in reset", mode_sel, m);
    repeat (eff(w_ms) - 1) @(negedge clk);
    chk(!tgt_rst_n, "R5 setup wait", tgt_rst_n, 0);
    @(negedge clk);
    chk(tgt_rst_n && ready && !idle && vpp_en, "R6 running", ready, 1);
  endtask

  task automatic shut_from_run(input bit use_abort);
    int n;
    rst_bad = 0;
    if (use_abort) abort = 1; else done = 1;
    @(negedge clk); abort = 0; done = 0;
    watch = 1;
    chk(!tgt_rst_n && !vpp_en && ea_hv_en && vcc_en && !ready, use_abort ? "R11 abort from run" : "R8 done reset+vpp", vpp_en, 0);
    span(1, 1, n);
    chk(n == eff(w_hd), "R9 vpp off wait", n, eff(w_hd));
    chk(!ea_hv_en && vcc_en, "R9 ea removed", vcc_en, 1);
    span(0, 1, n);
    chk(n == eff(w_hd), "R9 ea off wait", n, eff(w_hd));
    chk(!vcc_en && !idle, "R9 core removed", idle, 0);
    span(4, 0, n);
    chk(n == eff(w_vd), "R9 decay wait", n, eff(w_vd));
    chk(idle && mode_sel == 0, "R9 idle, mode cleared", mode_sel, 0);
    watch = 0;
    chk(rst_bad == 0, "R8 reset held low", rst_bad, 0);
  endtask

  task automatic t_reset;
    chk(idle && !vcc_en && !ea_hv_en && !vpp_en && !tgt_rst_n && !ready && mode_sel == 0,
        "R1 reset state", {idle, vcc_en, ea_hv_en, vpp_en, tgt_rst_n, ready}, 6'b100000);
  endtask

  task automatic t_full_cycle;
    set_waits(3, 4, 5, 2, 3, 6);
    power_up(4'hA);
    cfg_mode = 4'h3;
    repeat (4) @(negedge clk);
    chk(mode_sel == 4'hA && ready, "R7 mode frozen", mode_sel, 4'hA);
    pulse(start);
    chk(ready && mode_sel == 4'hA, "R12 start ignored in run", ready, 1);
    shut_from_run(0);
  endtask

  task automatic t_zero_waits;
    set_waits(0, 0, 0, 0, 0, 0);
    power_up(4'h5);
    shut_from_run(0);
  endtask

  task automatic t_abort_vcc;
    int n;
    set_waits(10, 2, 2, 2, 2, 4);
    pulse(start);
    @(negedge clk);
    pulse(abort);
    chk(!vcc_en && !ea_hv_en && !vpp_en && !tgt_rst_n && !idle, "R11 abort in core wait", vcc_en, 0);
    span(4, 0, n);
    chk(n == 4, "R11 decay after abort", n, 4);
  endtask

  task automatic t_abort_ea;
    int n;
    set_waits(2, 10, 2, 2, 3, 2);
    pulse(start);
    span(1, 0, n);
    pulse(abort);
    chk(!ea_hv_en && vcc_en && !vpp_en && !tgt_rst_n, "R11 abort in ea wait", ea_hv_en, 0);
    span(0, 1, n);
    chk(n == 3, "R11 ea off wait after abort", n, 3);
    span(4, 0, n);
    chk(n == 2 && idle, "R11 idle after abort", n, 2);
  endtask

  task automatic t_done_ignored;
    int n;
    set_waits(1, 1, 8, 2, 1, 1);
    pulse(start);
    span(2, 0, n);
    pulse(done);
    chk(vpp_en && ea_hv_en && !tgt_rst_n, "R12 done ignored before run", vpp_en, 1);
    span(3, 0, n);
    chk(n == 7 + 2, "R12 power-up unaffected by done", n, 9);
    shut_from_run(1);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_cycle();
    t_zero_waits();
    t_abort_vcc();
    t_abort_ea();
    t_done_ignored();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule